// File: doc/BRIEF.md
# Operand Latency Scoreboard with Bypass Exceptions

This block sits beside the issue stage of an in-order pipeline and answers one question every cycle: may the presented consumer operation issue now, or must it wait because a source register is still being produced? It keeps one tracking entry per architectural register. When a producer issues, the entry of its destination records the producer's operation class and starts a countdown from that class's default latency.

A consumer presents its class, up to two source registers with use bits, and three flags per source. The flags mark a source that is needed by the early shift stage, a source that feeds only the accumulator input, and a source that supplies only the value to be stored. For each source the block selects an effective latency from the producer/consumer class pair and these flags. The selected latency is often shorter than the default. The block raises `stall` while fewer cycles than that have elapsed since the producer issued. A producer and a consumer presented in the same cycle count as zero elapsed cycles, so a zero-latency pair may issue together.

Each entry is a two-state machine. `S_IDLE` means no write is pending. `S_BUSY` means a write is pending and the countdown is running. The transitions are:
- RECORD (`S_IDLE`→`S_BUSY`): a producer with latency of at least 2 is recorded.
- RELOAD (`S_BUSY`→`S_BUSY`): a newer producer to the same register replaces the entry.
- TICK (`S_BUSY`→`S_BUSY`): the countdown steps down by one.
- DRAIN (`S_BUSY`→`S_IDLE`): the count reaches zero.
- SUPERSEDE (`S_BUSY`→`S_IDLE`): a newer producer of latency 1 replaces the entry.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset no register is pending, and `stall` is low for any consumer on any register.
- R2: `stall` is high only when `cons_valid` is high and some source with its use bit set names a pending register whose effective latency has not elapsed. Sources with the use bit clear are ignored.
- R3: Class codes are: 0 ALU (including shifted forms), 1 move, 2 single/double load, 3 three/four-register load, 4 multiply, 5 multiply-accumulate, 6 long multiply, 7 short single-cycle multiply, 8 dual-accumulate long multiply, 9 store, 10 branch, 11 call. With no bypass, the latencies are 2, 1, 3, 5, 6, 6, 7, 5, 6, 0, 0, 32 in that code order. Classes of latency 0 record no destination.
- R4: A move feeding an ALU consumer whose source flag "early" (bit of `cons_early`) is clear has latency 0, so both may be presented in the same cycle without stall.
- R5: An ALU producer feeding an ALU consumer without the early flag has latency 1.
- R6: Any multiply class (codes 4 to 8) feeding an ALU consumer without the early flag has latency 4.
- R7: A multiply, multiply-accumulate or short multiply (codes 4, 5, 7) feeding a multiply-accumulate consumer through a source flagged accumulator-only (`cons_acc`) has latency 1. The dual-accumulate long (8) and long (6) classes keep their default latency.
- R8: A single/double load feeding an ALU consumer without the early flag has latency 2. A three/four-register load in the same case has latency 4.
- R9: An ALU or move result used by a store consumer through a source flagged store-data-only (`cons_sdata`) has latency 0.
- R10: A call holds its destination pending for 32 cycles.
- R11: A newer producer to a register that already has a pending write replaces the older entry, and later consumers are timed only from the newer producer.
- R12: A set early flag disables the ALU-consumer bypasses, so the default latency applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | A producer issues this cycle |
| prod_dst | input | 4 | Producer destination register |
| prod_class | input | 4 | Producer class code (R3) |
| cons_valid | input | 1 | A consumer is presented this cycle |
| cons_class | input | 4 | Consumer class code (R3) |
| cons_src | input | 2x4 | Source register per slot |
| cons_use | input | 2 | Source slot in use |
| cons_early | input | 2 | Source needed by the early shift stage |
| cons_acc | input | 2 | Source feeds only the accumulator |
| cons_sdata | input | 2 | Source is only the stored value |
| stall | output | 1 | Consumer must wait |

## Verification
The bench measures the first non-stalling cycle for every producer/consumer pairing that has a bypass, and for pairings next to each one that lack it: the excluded dual-accumulate class, an early-flagged source, and a store address use. A design that applied bypasses too broadly would release the consumer early on these neighbours. A design with an off-by-one in the countdown load would shift every measured latency by one. The same-cycle move pairing catches a design that forgets the combinational path for a producer issuing now, since it would stall for one cycle. The replacement tests catch an entry that keeps timing from the older producer.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;
    localparam int LAT_W = 6;

    typedef enum logic [3:0] {
        OC_ALU   = 4'd0,
        OC_MOV   = 4'd1,
        OC_LD12  = 4'd2,
        OC_LD34  = 4'd3,
        OC_MUL   = 4'd4,
        OC_MLA   = 4'd5,
        OC_MULL  = 4'd6,
        OC_MULS  = 4'd7,
        OC_MLALD = 4'd8,
        OC_STORE = 4'd9,
        OC_BR    = 4'd10,
        OC_CALL  = 4'd11
    } opclass_e;

    // Latency of a class when no bypass applies.
    function automatic logic [LAT_W-1:0] base_lat(input logic [3:0] cls);
        logic [LAT_W-1:0] r;
        unique case (cls)
            OC_ALU:   r = LAT_W'(2);
            OC_MOV:   r = LAT_W'(1);
            OC_LD12:  r = LAT_W'(3);
            OC_LD34:  r = LAT_W'(5);
            OC_MUL:   r = LAT_W'(6);
            OC_MLA:   r = LAT_W'(6);
            OC_MULL:  r = LAT_W'(7);
            OC_MULS:  r = LAT_W'(5);
            OC_MLALD: r = LAT_W'(6);
            OC_CALL:  r = LAT_W'(32);
            default:  r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lat_sb_entry.sv
module lat_sb_entry
    import lat_sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [3:0]       load_cls,
    input  logic [LAT_W-1:0] load_lat,
    output logic             busy,
    output logic [LAT_W-1:0] rem,
    output logic [3:0]       cls
);
    typedef enum logic {S_IDLE, S_BUSY} ent_state_e;

    ent_state_e       state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic [3:0]       cls_q, cls_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            cls_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cls_q   <= cls_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cls_d   = cls_q;
        unique case (state_q)
            S_IDLE: begin
                if (load && load_lat > LAT_W'(1)) begin       // RECORD
                    state_d = S_BUSY;
                    cnt_d   = load_lat - LAT_W'(1);
                    cls_d   = load_cls;
                end
            end
            S_BUSY: begin
                if (load) begin
                    cls_d = load_cls;
                    if (load_lat > LAT_W'(1)) begin           // RELOAD
                        cnt_d = load_lat - LAT_W'(1);
                    end else begin                            // SUPERSEDE
                        state_d = S_IDLE;
                        cnt_d   = '0;
                    end
                end else if (cnt_q == LAT_W'(1)) begin        // DRAIN
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else begin                                // TICK
                    cnt_d = cnt_q - LAT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        busy = (state_q == S_BUSY);
        rem  = cnt_q;
        cls  = cls_q;
    end
endmodule

// File: rtl/lat_sb_bypass.sv
module lat_sb_bypass
    import lat_sb_pkg::*;
(
    input  logic [3:0]       prod_cls,
    input  logic [3:0]       cons_cls,
    input  logic             early,
    input  logic             acc,
    input  logic             sdata,
    output logic [LAT_W-1:0] eff_lat
);
    logic is_mul_any, is_mul_single;

    always_comb begin
        is_mul_any    = (prod_cls == OC_MUL) || (prod_cls == OC_MLA) ||
                        (prod_cls == OC_MULL) || (prod_cls == OC_MULS) ||
                        (prod_cls == OC_MLALD);
        is_mul_single = (prod_cls == OC_MUL) || (prod_cls == OC_MLA) ||
                        (prod_cls == OC_MULS);
        eff_lat = base_lat(prod_cls);
        if (cons_cls == OC_ALU && !early) begin
            if (prod_cls == OC_MOV)       eff_lat = LAT_W'(0);
            else if (prod_cls == OC_ALU)  eff_lat = LAT_W'(1);
            else if (prod_cls == OC_LD12) eff_lat = LAT_W'(2);
            else if (prod_cls == OC_LD34) eff_lat = LAT_W'(4);
            else if (is_mul_any)          eff_lat = LAT_W'(4);
        end else if (cons_cls == OC_MLA && acc && is_mul_single) begin
            eff_lat = LAT_W'(1);
        end else if (cons_cls == OC_STORE && sdata &&
                     (prod_cls == OC_ALU || prod_cls == OC_MOV)) begin
            eff_lat = LAT_W'(0);
        end
    end
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
    import lat_sb_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int NSRC  = 2,
    localparam int RW   = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prod_valid,
    input  logic [RW-1:0]            prod_dst,
    input  logic [3:0]               prod_class,
    input  logic                     cons_valid,
    input  logic [3:0]               cons_class,
    input  logic [NSRC-1:0][RW-1:0]  cons_src,
    input  logic [NSRC-1:0]          cons_use,
    input  logic [NSRC-1:0]          cons_early,
    input  logic [NSRC-1:0]          cons_acc,
    input  logic [NSRC-1:0]          cons_sdata,
    output logic                     stall
);
    logic [NREGS-1:0]             ent_busy;
    logic [NREGS-1:0][LAT_W-1:0]  ent_rem;
    logic [NREGS-1:0][3:0]        ent_cls;
    logic [LAT_W-1:0]             prod_lat;
    logic                         prod_rec;
    logic [NSRC-1:0]              src_hit;

    assign prod_lat = base_lat(prod_class);
    assign prod_rec = prod_valid && (prod_lat != '0);

    for (genvar r = 0; r < NREGS; r++) begin : g_ent
        lat_sb_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (prod_rec && (prod_dst == RW'(r))),
            .load_cls (prod_class),
            .load_lat (prod_lat),
            .busy     (ent_busy[r]),
            .rem      (ent_rem[r]),
            .cls      (ent_cls[r])
        );
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic             same_cyc;
        logic [3:0]       pcls;
        logic [LAT_W-1:0] eff, dflt;

        assign same_cyc = prod_rec && (prod_dst == cons_src[s]);
        assign pcls     = same_cyc ? prod_class : ent_cls[cons_src[s]];
        assign dflt     = base_lat(pcls);

        lat_sb_bypass u_byp (
            .prod_cls (pcls),
            .cons_cls (cons_class),
            .early    (cons_early[s]),
            .acc      (cons_acc[s]),
            .sdata    (cons_sdata[s]),
            .eff_lat  (eff)
        );

        always_comb begin
            if (!cons_valid || !cons_use[s])  src_hit[s] = 1'b0;
            else if (same_cyc)                src_hit[s] = (eff != '0);
            else                              src_hit[s] = ent_busy[cons_src[s]] &&
                                                           (ent_rem[cons_src[s]] > (dflt - eff));
        end
    end

    assign stall = |src_hit;
endmodule

// File: rtl/lat_scoreboard_chk.sv
module lat_scoreboard_chk
    import lat_sb_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int RW    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          prod_valid,
    input logic [RW-1:0]                 prod_dst,
    input logic [3:0]                    prod_class,
    input logic                          cons_valid,
    input logic                          stall,
    input logic [NREGS-1:0]              ent_busy,
    input logic [NREGS-1:0][LAT_W-1:0]   ent_rem
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ent_busy == '0));

    p_no_consumer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_valid |-> !stall);

    p_nothing_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_busy == '0 && !prod_valid) |-> !stall);

    p_record_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && base_lat(prod_class) > LAT_W'(1)) |=>
        (ent_busy[$past(prod_dst)] &&
         ent_rem[$past(prod_dst)] == $past(base_lat(prod_class)) - LAT_W'(1)));

    p_call_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && prod_class == OC_CALL) |=> (ent_rem[$past(prod_dst)] == LAT_W'(31)));

    for (genvar i = 0; i < NREGS; i++) begin : g_chk
        p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_busy[i] && !(prod_valid && prod_dst == RW'(i) && base_lat(prod_class) != '0))
            |=> (ent_rem[i] == $past(ent_rem[i]) - LAT_W'(1)));

        p_busy_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ent_busy[i] |-> (ent_rem[i] != '0));
    end
endmodule

bind lat_scoreboard lat_scoreboard_chk #(.NREGS(NREGS), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_valid (prod_valid),
    .prod_dst   (prod_dst),
    .prod_class (prod_class),
    .cons_valid (cons_valid),
    .stall      (stall),
    .ent_busy   (ent_busy),
    .ent_rem    (ent_rem)
);

// File: tb/tb_lat_scoreboard.sv
module tb_lat_scoreboard;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 31;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            prod_valid;
    logic [3:0]      prod_dst, prod_class;
    logic            cons_valid;
    logic [3:0]      cons_class;
    logic [1:0][3:0] cons_src;
    logic [1:0]      cons_use, cons_early, cons_acc, cons_sdata;
    logic            stall;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_scoreboard dut (
        .clk(clk), .rst_n(rst_n),
        .prod_valid(prod_valid), .prod_dst(prod_dst), .prod_class(prod_class),
        .cons_valid(cons_valid), .cons_class(cons_class), .cons_src(cons_src),
        .cons_use(cons_use), .cons_early(cons_early), .cons_acc(cons_acc),
        .cons_sdata(cons_sdata), .stall(stall)
    );

    // {producer class, consumer class, early, acc, sdata, expected latency, requirement}
    localparam logic [20:0] VEC [NV] = '{
        {4'd1, 4'd0, 3'b000, 6'd0,  4'd4},   // R4 move -> ALU
        {4'd1, 4'd0, 3'b100, 6'd1,  4'd12},  // R12 move -> ALU early
        {4'd0, 4'd0, 3'b000, 6'd1,  4'd5},   // R5 ALU -> ALU
        {4'd0, 4'd0, 3'b100, 6'd2,  4'd12},  // R12 ALU -> ALU early
        {4'd4, 4'd0, 3'b000, 6'd4,  4'd6},   // R6 mul -> ALU
        {4'd5, 4'd0, 3'b000, 6'd4,  4'd6},   // R6 mla -> ALU
        {4'd6, 4'd0, 3'b000, 6'd4,  4'd6},   // R6 long -> ALU
        {4'd7, 4'd0, 3'b000, 6'd4,  4'd6},   // R6 short -> ALU
        {4'd8, 4'd0, 3'b000, 6'd4,  4'd6},   // R6 dual-acc -> ALU
        {4'd5, 4'd0, 3'b100, 6'd6,  4'd12},  // R12 mla -> ALU early
        {4'd2, 4'd0, 3'b000, 6'd2,  4'd8},   // R8 load -> ALU
        {4'd3, 4'd0, 3'b000, 6'd4,  4'd8},   // R8 multi-load -> ALU
        {4'd2, 4'd0, 3'b100, 6'd3,  4'd12},  // R12 load -> ALU early
        {4'd3, 4'd0, 3'b100, 6'd5,  4'd12},  // R12 multi-load -> ALU early
        {4'd4, 4'd5, 3'b010, 6'd1,  4'd7},   // R7 mul -> acc
        {4'd5, 4'd5, 3'b010, 6'd1,  4'd7},   // R7 mla -> acc
        {4'd7, 4'd5, 3'b010, 6'd1,  4'd7},   // R7 short -> acc
        {4'd8, 4'd5, 3'b010, 6'd6,  4'd7},   // R7 dual-acc excluded
        {4'd6, 4'd5, 3'b010, 6'd7,  4'd7},   // R7 long excluded
        {4'd4, 4'd5, 3'b000, 6'd6,  4'd7},   // R7 not accumulator
        {4'd0, 4'd9, 3'b001, 6'd0,  4'd9},   // R9 ALU -> store data
        {4'd1, 4'd9, 3'b001, 6'd0,  4'd9},   // R9 move -> store data
        {4'd0, 4'd9, 3'b000, 6'd2,  4'd9},   // R9 ALU -> store address
        {4'd4, 4'd9, 3'b001, 6'd6,  4'd9},   // R9 mul -> store data, no bypass
        {4'd11, 4'd0, 3'b000, 6'd32, 4'd10}, // R10 call
        {4'd1, 4'd10, 3'b000, 6'd1, 4'd3},   // R3 move default
        {4'd2, 4'd10, 3'b000, 6'd3, 4'd3},   // R3 load default
        {4'd3, 4'd10, 3'b000, 6'd5, 4'd3},   // R3 multi-load default
        {4'd6, 4'd10, 3'b000, 6'd7, 4'd3},   // R3 long default
        {4'd7, 4'd10, 3'b000, 6'd5, 4'd3},   // R3 short default
        {4'd9, 4'd0, 3'b000, 6'd0,  4'd3}    // R3 store records nothing
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        prod_valid = 1'b0; prod_dst = '0; prod_class = '0;
        cons_valid = 1'b0; cons_class = '0; cons_src = '0;
        cons_use = '0; cons_early = '0; cons_acc = '0; cons_sdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure(input logic [3:0] pc, input logic [3:0] cc,
                           input logic [2:0] fl, output int got);
        @(negedge clk);
        prod_valid = 1'b1; prod_dst = 4'd3; prod_class = pc;
        cons_valid = 1'b1; cons_class = cc; cons_src[0] = 4'd3; cons_use = 2'b01;
        cons_early[0] = fl[2]; cons_acc[0] = fl[1]; cons_sdata[0] = fl[0];
        #1;
        got = stall ? -1 : 0;
        for (int d = 1; d <= 40 && got < 0; d++) begin
            @(negedge clk);
            prod_valid = 1'b0;
            #1;
            if (!stall) got = d;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();

        // Table walk: measured latency per pairing
        for (int v = 0; v < NV; v++) begin
            int got;
            do_reset();
            measure(VEC[v][20:17], VEC[v][16:13], VEC[v][12:10], got);
            chk($sformatf("R%0d vector %0d", VEC[v][3:0], v), got, int'(VEC[v][9:4]));
        end

        // R1: nothing pending after reset
        do_reset();
        @(negedge clk);
        cons_valid = 1'b1; cons_class = 4'd0; cons_use = 2'b11;
        cons_src[0] = 4'd0; cons_src[1] = 4'd15;
        #1 chk("R1 reset stall", int'(stall), 0);

        // R2: unused source ignored, consumer valid required
        do_reset();
        @(negedge clk);
        prod_valid = 1'b1; prod_dst = 4'd5; prod_class = 4'd3;
        @(negedge clk);
        idle_inputs();
        cons_valid = 1'b1; cons_class = 4'd0;
        cons_src[0] = 4'd5; cons_src[1] = 4'd5; cons_use = 2'b10;
        #1 chk("R2 second source pending", int'(stall), 1);
        cons_use = 2'b00;
        #1 chk("R2 unused sources ignored", int'(stall), 0);
        cons_use = 2'b11; cons_valid = 1'b0;
        #1 chk("R2 no consumer", int'(stall), 0);
        cons_valid = 1'b1; cons_src[0] = 4'd6; cons_src[1] = 4'd6;
        #1 chk("R2 other register", int'(stall), 0);

        // R11: move replaces pending multi-load
        do_reset();
        @(negedge clk);
        prod_valid = 1'b1; prod_dst = 4'd7; prod_class = 4'd3;
        @(negedge clk);
        prod_class = 4'd1;
        @(negedge clk);
        idle_inputs();
        cons_valid = 1'b1; cons_class = 4'd0; cons_src[0] = 4'd7; cons_use = 2'b01;
        #1 chk("R11 move supersedes load", int'(stall), 0);

        // R11: load replaces pending move
        do_reset();
        @(negedge clk);
        prod_valid = 1'b1; prod_dst = 4'd8; prod_class = 4'd1;
        @(negedge clk);
        prod_class = 4'd2;
        @(negedge clk);
        idle_inputs();
        cons_valid = 1'b1; cons_class = 4'd0; cons_src[0] = 4'd8; cons_use = 2'b01;
        cons_early = 2'b01;
        #1 chk("R11 load replaces move", int'(stall), 1);
        @(negedge clk);
        #1 chk("R11 load replaces move, cycle 2", int'(stall), 1);
        @(negedge clk);
        #1 chk("R11 load replaces move, released", int'(stall), 0);

        // R4: same-cycle move and ALU on second slot
        do_reset();
        @(negedge clk);
        prod_valid = 1'b1; prod_dst = 4'd2; prod_class = 4'd1;
        cons_valid = 1'b1; cons_class = 4'd0; cons_src[1] = 4'd2; cons_use = 2'b10;
        #1 chk("R4 same cycle slot 1", int'(stall), 0);
        @(negedge clk);
        idle_inputs();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule